// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block owns a small byte-addressable configuration space and uses it to place two I/O windows in a 16-bit I/O address space. One is a 128-byte power-management window and the other is a 16-byte SMBus window. Each window has a 32-bit base register and a separate enable bit in another configuration byte. The block sets the fixed bits of the base registers and clears reserved bits as they are written, so software can write all ones and read back the window size.

A configuration write carries a dword index, a byte-enable mask and 32 bits of data. Every enabled lane is merged in one cycle. Reads are combinational and return the stored dword. The I/O side is purely combinational. An I/O address produces one hit flag per window and an offset relative to the window base. When both windows match, the power-management window takes precedence.

Top module: `io_win_decoder`

## Requirements
- R1: After reset, every configuration byte from 0x40 to 0xFF reads 0, except bytes 0x48 and 0x90, which read 1. Both hit outputs are low for every I/O address.
- R2: A write to the power-management base dword (byte offsets 0x48–0x4B, dword index 0x12) stores each enabled lane of (data AND 0x0000FF80) OR 1. Bytes 0x4A and 0x4B always read 0, and bit 0 reads 1.
- R3: A write to the SMBus base dword (byte offsets 0x90–0x93, dword index 0x24) stores each enabled lane of (data AND 0x0000FFF0) OR 1.
- R4: A write to byte 0xD2 (lane 2 of dword index 0x34) stores only its low four bits and clears bits 7:4. Bytes 0xD0, 0xD1 and 0xD3 store the written value.
- R5: Only lanes whose byte-enable bit is set change. A partial write to a base dword leaves the other lanes unchanged, so bit 0 still reads 1.
- R6: Dword indices 0x00–0x0F (the 64-byte header) always read 0, and writes to them are ignored.
- R7: The power-management hit is high exactly when bit 7 of byte 0x41 is set and I/O address bits 15:7 equal base bits 15:7.
- R8: The SMBus hit is high exactly when bit 0 of byte 0xD2 is set and I/O address bits 15:4 equal base bits 15:4.
- R9: The offset output equals I/O address bits 6:0 when the power-management window hits. Otherwise it equals bits 3:0, zero-extended, when the SMBus window hits. Otherwise it is 0.
- R10: Any other byte from 0x40 to 0xFF stores the written value unchanged and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Dword index for read and write |
| cfg_be_i | input | 4 | Byte-lane enables for write |
| cfg_wdata_i | input | 32 | Write data, lane 0 in bits 7:0 |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| io_addr_i | input | 16 | I/O address to decode |
| pm_hit_o | output | 1 | Power-management window hit |
| smb_hit_o | output | 1 | SMBus window hit |
| win_ofs_o | output | 7 | Offset inside the hitting window |

## Verification
The bench sweeps all 65536 I/O addresses after reset, with two disjoint enabled windows, with overlapping windows, and with one window gated off.

Each sweep guards against a specific fault:
- A wrong base mask would shift or resize a window.
- A missing enable gate would hit while the window is disabled.
- Wrong priority would return the SMBus offset inside the overlap.

Register checks cover the reserved upper bytes of the base registers, bit 0 surviving a partial write, the cleared nibble of the enable byte, and the ignored header. A fault there would show up as a bit that reads back wrong.

// File: rtl/io_win_pkg.sv
`timescale 1ns/1ps
package io_win_pkg;
  localparam int IO_AW        = 16;
  localparam int CFG_BYTES    = 256;
  localparam int HDR_BYTES    = 64;
  localparam int CFG_WA       = $clog2(CFG_BYTES / 4);
  localparam int PM_BASE_OFS  = 'h48;
  localparam int PM_EN_OFS    = 'h41;
  localparam int PM_EN_BIT    = 7;
  localparam int SMB_BASE_OFS = 'h90;
  localparam int SMB_EN_OFS   = 'hD2;
  localparam int SMB_EN_BIT   = 0;
  localparam logic [7:0] SMB_EN_KEEP = 8'h0F;
endpackage

// File: rtl/io_win_cfg_regs.sv
`timescale 1ns/1ps
module io_win_cfg_regs
  import io_win_pkg::*;
#(
  parameter int PM_WB  = 7,
  parameter int SMB_WB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_WA-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              pm_en_o,
  output logic [IO_AW-1:0]  pm_base_o,
  output logic              smb_en_o,
  output logic [IO_AW-1:0]  smb_base_o
);
  localparam int NB = CFG_BYTES - HDR_BYTES;
  localparam logic [31:0] PM_WMASK  = ((32'd1 << IO_AW) - 1) & ~((32'd1 << PM_WB) - 1);
  localparam logic [31:0] SMB_WMASK = ((32'd1 << IO_AW) - 1) & ~((32'd1 << SMB_WB) - 1);
  localparam logic [CFG_WA-1:0] PM_WORD  = CFG_WA'(PM_BASE_OFS / 4);
  localparam logic [CFG_WA-1:0] SMB_WORD = CFG_WA'(SMB_BASE_OFS / 4);
  localparam logic [CFG_WA-1:0] SEN_WORD = CFG_WA'(SMB_EN_OFS / 4);
  localparam int SEN_LANE = SMB_EN_OFS % 4;

  // bits a write may change in byte at offset ofs
  function automatic logic [7:0] keep_of(int ofs);
    if (ofs >= PM_BASE_OFS && ofs < PM_BASE_OFS + 4)
      return PM_WMASK[8*(ofs-PM_BASE_OFS) +: 8];
    if (ofs >= SMB_BASE_OFS && ofs < SMB_BASE_OFS + 4)
      return SMB_WMASK[8*(ofs-SMB_BASE_OFS) +: 8];
    if (ofs == SMB_EN_OFS) return SMB_EN_KEEP;
    return 8'hFF;
  endfunction

  // hard-wired ones; also the reset value
  function automatic logic [7:0] set_of(int ofs);
    if (ofs == PM_BASE_OFS || ofs == SMB_BASE_OFS) return 8'h01;
    return 8'h00;
  endfunction

  logic [7:0] mem_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= set_of(HDR_BYTES + i);
    end else if (we_i) begin
      for (int i = 0; i < NB; i++) begin
        if (addr_i == CFG_WA'((HDR_BYTES + i) / 4) && be_i[(HDR_BYTES + i) % 4])
          mem_q[i] <= (wdata_i[8*((HDR_BYTES + i) % 4) +: 8] & keep_of(HDR_BYTES + i))
                      | set_of(HDR_BYTES + i);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < 4; l++) begin
      if (int'(addr_i) * 4 + l >= HDR_BYTES)
        rdata_o[8*l +: 8] = mem_q[int'(addr_i) * 4 + l - HDR_BYTES];
    end
  end

  assign pm_en_o    = mem_q[PM_EN_OFS - HDR_BYTES][PM_EN_BIT];
  assign pm_base_o  = {mem_q[PM_BASE_OFS + 1 - HDR_BYTES], mem_q[PM_BASE_OFS - HDR_BYTES]};
  assign smb_en_o   = mem_q[SMB_EN_OFS - HDR_BYTES][SMB_EN_BIT];
  assign smb_base_o = {mem_q[SMB_BASE_OFS + 1 - HDR_BYTES], mem_q[SMB_BASE_OFS - HDR_BYTES]};

  p_pm_lsb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PM_WORD && be_i[0]) |=> pm_base_o[PM_WB-1:0] == PM_WB'(1));
  p_smb_lsb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SMB_WORD && be_i[0]) |=> smb_base_o[SMB_WB-1:0] == SMB_WB'(1));
  p_nib_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEN_WORD && be_i[SEN_LANE]) |=> mem_q[SMB_EN_OFS - HDR_BYTES][7:4] == 4'h0);
  p_lane_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PM_WORD && !be_i[1]) |=> $stable(pm_base_o[15:8]));
  p_hdr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) < HDR_BYTES / 4) |-> rdata_o == 32'h0);
endmodule

// File: rtl/io_win_match.sv
`timescale 1ns/1ps
module io_win_match #(
  parameter int AW = 16,
  parameter int WB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [WB-1:0] ofs_o
);
  localparam logic [AW-1:0] MSK = ~AW'((1 << WB) - 1);

  logic [AW-1:0] base_m;
  assign base_m = base_i & MSK;
  assign hit_o  = en_i && ((addr_i & MSK) == base_m);
  assign ofs_o  = WB'(addr_i - base_m);

  p_gate_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o);
  p_ofs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ofs_o == addr_i[WB-1:0]);
endmodule

// File: rtl/io_win_decoder.sv
`timescale 1ns/1ps
module io_win_decoder
  import io_win_pkg::*;
#(
  parameter int PM_WIN_BITS  = 7,
  parameter int SMB_WIN_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_WA-1:0]    cfg_addr_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [31:0]          cfg_wdata_i,
  output logic [31:0]          cfg_rdata_o,
  input  logic [IO_AW-1:0]     io_addr_i,
  output logic                 pm_hit_o,
  output logic                 smb_hit_o,
  output logic [((PM_WIN_BITS > SMB_WIN_BITS) ? PM_WIN_BITS : SMB_WIN_BITS)-1:0] win_ofs_o
);
  localparam int OFS_W = (PM_WIN_BITS > SMB_WIN_BITS) ? PM_WIN_BITS : SMB_WIN_BITS;
  localparam int NW    = 2;

  logic             pm_en, smb_en;
  logic [IO_AW-1:0] pm_base, smb_base;
  logic [NW-1:0]    en_w, hit_w;
  logic [IO_AW-1:0] base_w [NW];
  logic [OFS_W-1:0] ofs_w  [NW];

  io_win_cfg_regs #(.PM_WB(PM_WIN_BITS), .SMB_WB(SMB_WIN_BITS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .be_i       (cfg_be_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .pm_en_o    (pm_en),
    .pm_base_o  (pm_base),
    .smb_en_o   (smb_en),
    .smb_base_o (smb_base)
  );

  assign en_w      = {smb_en, pm_en};
  assign base_w[0] = pm_base;
  assign base_w[1] = smb_base;

  for (genvar g = 0; g < NW; g++) begin : g_win
    localparam int WB = (g == 0) ? PM_WIN_BITS : SMB_WIN_BITS;
    logic [WB-1:0] ofs;
    io_win_match #(.AW(IO_AW), .WB(WB)) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_w[g]),
      .base_i (base_w[g]),
      .addr_i (io_addr_i),
      .hit_o  (hit_w[g]),
      .ofs_o  (ofs)
    );
    assign ofs_w[g] = OFS_W'(ofs);
  end

  // lowest index (power management) wins on overlap
  always_comb begin
    win_ofs_o = '0;
    for (int g = NW - 1; g >= 0; g--)
      if (hit_w[g]) win_ofs_o = ofs_w[g];
  end

  assign pm_hit_o  = hit_w[0];
  assign smb_hit_o = hit_w[1];

  p_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> win_ofs_o == OFS_W'(io_addr_i[PM_WIN_BITS-1:0]));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_hit_o && !smb_hit_o) |-> win_ofs_o == '0);
endmodule

// File: tb/io_win_decoder_tb.sv
`timescale 1ns/1ps
module io_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] io = '0;
  logic        pm_hit, smb_hit;
  logic [6:0]  ofs;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m [256];

  always #2.5 clk = ~clk;

  io_win_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .io_addr_i(io), .pm_hit_o(pm_hit), .smb_hit_o(smb_hit), .win_ofs_o(ofs)
  );

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m['h48] = 8'h01;
    m['h90] = 8'h01;
  endtask

  function automatic logic [7:0] model_byte(int b, logic [7:0] v);
    case (b)
      'h48: return (v & 8'h80) | 8'h01;
      'h4A, 'h4B, 'h92, 'h93: return 8'h00;
      'h90: return (v & 8'hF0) | 8'h01;
      'hD2: return v & 8'h0F;
      default: return v;
    endcase
  endfunction

  task automatic cfg_wr(input logic [5:0] a, input logic [3:0] e, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = e; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = '0;
    for (int l = 0; l < 4; l++) begin
      if (e[l] && int'(a) * 4 + l >= 64)
        m[int'(a) * 4 + l] = model_byte(int'(a) * 4 + l, d[8*l +: 8]);
    end
  endtask

  task automatic cfg_chk(input logic [5:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    addr = a;
    #1;
    exp = {m[int'(a)*4+3], m[int'(a)*4+2], m[int'(a)*4+1], m[int'(a)*4]};
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s dword 0x%02h: got %08h expected %08h", tag, a, rdata, exp);
    end
  endtask

  // full I/O sweep, counted as one check
  task automatic sweep(input string tag);
    logic pe, se, eph, esh;
    logic [15:0] pb, sb;
    logic [6:0] eo;
    int bad = 0;
    pe = m['h41][7];
    se = m['hD2][0];
    pb = {m['h49], m['h48]} & 16'hFF80;
    sb = {m['h91], m['h90]} & 16'hFFF0;
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      io = 16'(a);
      #1;
      eph = pe && ((16'(a) & 16'hFF80) == pb);
      esh = se && ((16'(a) & 16'hFFF0) == sb);
      eo  = eph ? 7'(a) : (esh ? {3'b000, 4'(a)} : 7'd0);
      if ({pm_hit, smb_hit, ofs} !== {eph, esh, eo}) begin
        if (bad == 0) begin
          n_fail++;
          $display("FAIL %s io 0x%04h: got pm=%b smb=%b ofs=%0d expected pm=%b smb=%b ofs=%0d",
                   tag, a, pm_hit, smb_hit, ofs, eph, esh, eo);
        end
        bad++;
      end
    end
    n_chk++;
  endtask

  initial begin
    #900000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    #12 rst_n = 1'b1;
    // R1 reset state and R6 header
    for (int w = 0; w < 64; w++) cfg_chk(6'(w), (w < 16) ? "R6 reset" : "R1 reset");
    sweep("R1 idle sweep");
    // R6 header writes ignored
    for (int w = 0; w < 16; w++) cfg_wr(6'(w), 4'hF, 32'hFFFF_FFFF);
    for (int w = 0; w < 16; w++) cfg_chk(6'(w), "R6 header write");
    // R10 plain bytes
    cfg_wr(6'h20, 4'hF, 32'hDEAD_BEEF); cfg_chk(6'h20, "R10 plain");
    cfg_wr(6'h3F, 4'hF, 32'hA5A5_5A5A); cfg_chk(6'h3F, "R10 plain");
    cfg_wr(6'h11, 4'h5, 32'h1234_5678); cfg_chk(6'h11, "R10 R5 lanes");
    // R2 power-management base
    cfg_wr(6'h12, 4'hF, 32'hFFFF_FFFF); cfg_chk(6'h12, "R2 pm base all ones");
    cfg_wr(6'h12, 4'h1, 32'h0000_0000); cfg_chk(6'h12, "R5 partial low lane");
    cfg_wr(6'h12, 4'hC, 32'hFFFF_0000); cfg_chk(6'h12, "R2 reserved lanes");
    // R3 SMBus base
    cfg_wr(6'h24, 4'hF, 32'h1234_5678); cfg_chk(6'h24, "R3 smb base");
    cfg_wr(6'h24, 4'h2, 32'h0000_0000); cfg_chk(6'h24, "R5 partial high lane");
    cfg_wr(6'h24, 4'h2, 32'h0000_5600); cfg_chk(6'h24, "R3 smb base restore");
    // R4 enable byte
    cfg_wr(6'h34, 4'hF, 32'hAAAA_AAAA); cfg_chk(6'h34, "R4 enable dword");
    cfg_wr(6'h34, 4'h4, 32'h00FF_0000); cfg_chk(6'h34, "R4 nibble clear");
    // R7 R8 enable both, disjoint windows
    cfg_wr(6'h10, 4'h2, 32'h0000_8000); cfg_chk(6'h10, "R7 pm enable");
    sweep("R7/R8/R9 disjoint");
    // R9 overlap priority
    cfg_wr(6'h12, 4'hF, 32'h0000_0100); cfg_chk(6'h12, "R2 pm base");
    cfg_wr(6'h24, 4'hF, 32'h0000_0145); cfg_chk(6'h24, "R3 smb base");
    sweep("R9 overlap");
    // R7 gate off power management only
    cfg_wr(6'h10, 4'h2, 32'h0000_7F00); cfg_chk(6'h10, "R7 pm disable");
    sweep("R7 gated");
    // R8 gate off SMBus
    cfg_wr(6'h34, 4'h4, 32'h000E_0000); cfg_chk(6'h34, "R8 smb disable");
    sweep("R8 gated");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule